// File: doc/BRIEF.md
# Debug-Side Bit-Flip Trigger Unit

This block sits beside an on-chip debug unit and carries out a single fault insertion without help from the external debugger once it is armed. A debugger loads three values through a small configuration port: a trigger address, a target address and a faulty value. The faulty value is computed in advance so that one plain write leaves exactly one bit different from what the cell would hold. The debugger then arms the unit. The unit watches the CPU's instruction-fetch and data buses. On the first access that matches the trigger, it commits the fault.

A target in RAM is written through the RAM write port while the processor keeps running. There is no read-modify-write, so the program has almost no window in which to overwrite the cell. When the CPU is itself writing in the commit cycle, the unit yields for one cycle only. It then takes the port and stalls the CPU write. A target in the register file instead goes through a short halt, write, resume handshake. The unit records how many cycles passed from the trigger match to the commit. It also flags a CPU write to the target address made during the wait. It disarms itself after firing. The unit never touches program trace, so trace runs on unchanged through the insertion.

Top module: `flip_inject_unit`

## Requirements
- R1: After reset, no write, stall, halt or resume request is asserted, and the armed, done, collision and error flags and the delay field are all zero.
- R2: Configuration selector 1 holds the trigger address, selector 2 holds the target address and selector 3 holds the faulty value (low data bits). Selector 0 is control: bit 0 arms, bit 1 selects a data-access trigger (1) or an instruction-fetch trigger (0), and bit 2 selects a register target (1) or a RAM target (0). Arming sets the armed flag and clears the done, collision, error and delay status.
- R3: While armed, only the selected bus source can match the trigger address. A data-access trigger matches a read or a write. Accesses at other addresses, or on the other bus, cause no write.
- R4: For a RAM target, in the cycle after the match, if the CPU is not writing, the unit drives one RAM write of the faulty value to the target address. It never raises a halt request.
- R5: If the CPU writes in that cycle, the unit waits exactly one cycle. It then writes with the CPU stall output asserted.
- R6: Firing is one-shot. After the commit, the armed flag is low and the done flag is high, and later trigger matches cause no write until the unit is rearmed.
- R7: The delay field holds the number of cycles from the match cycle to the commit cycle. This is 1 for an immediate RAM write and 2 after a yield. The field saturates at its all-ones value.
- R8: The collision flag is set when the CPU writes the target address during the yield cycle. A CPU write to any other address leaves it clear.
- R9: For a register target, the halt request is held from the cycle after the match until halt-ack. The register write happens in the cycle after the ack. A one-cycle resume request follows, and then done is set.
- R10: Any configuration write while the unit is armed or firing is ignored and sets the error flag. The armed settings are still used when the unit fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register selector |
| cfg_wdata | input | AW | Configuration write data |
| fetch_valid | input | 1 | CPU instruction fetch in this cycle |
| fetch_addr | input | AW | CPU fetch address |
| dbus_valid | input | 1 | CPU data access in this cycle |
| dbus_we | input | 1 | CPU data access is a write |
| dbus_addr | input | AW | CPU data address |
| ram_we | output | 1 | Fault write to RAM |
| ram_addr | output | AW | RAM write address |
| ram_wdata | output | DW | RAM write data |
| cpu_stall | output | 1 | Holds off the CPU's RAM write |
| halt_req | output | 1 | Halt request to the core |
| halt_ack | input | 1 | Core reports it is halted |
| reg_we | output | 1 | Register-file fault write |
| reg_addr | output | AW | Register index |
| reg_wdata | output | DW | Register write data |
| resume_req | output | 1 | Resume request to the core |
| st_armed | output | 1 | Unit armed and waiting for its trigger |
| st_done | output | 1 | Fault committed since last arming |
| st_collide | output | 1 | CPU wrote the target while the fault waited |
| st_err | output | 1 | Configuration write refused |
| st_delay | output | DLYW | Cycles from match to commit |

## Verification
Several orderings are checked on every cycle. A fault write always leads to done with armed low on the next cycle. A stall only follows a CPU write. A register write always comes one cycle after a granted halt and is followed by a resume. At most one of the RAM write, register write and resume is active at a time, and a refused configuration write always shows up as the error flag. Other behaviour needs the bench's scenarios. These are the exact address and data of each commit under both trigger sources, the delay values including saturation, the collision flag when the target address or another address is written, and the one-shot and lockout behaviour.

// File: rtl/flip_inject_unit.sv
module flip_inject_unit #(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int DLYW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic            fetch_valid,
  input  logic [AW-1:0]   fetch_addr,
  input  logic            dbus_valid,
  input  logic            dbus_we,
  input  logic [AW-1:0]   dbus_addr,
  output logic            ram_we,
  output logic [AW-1:0]   ram_addr,
  output logic [DW-1:0]   ram_wdata,
  output logic            cpu_stall,
  output logic            halt_req,
  input  logic            halt_ack,
  output logic            reg_we,
  output logic [AW-1:0]   reg_addr,
  output logic [DW-1:0]   reg_wdata,
  output logic            resume_req,
  output logic            st_armed,
  output logic            st_done,
  output logic            st_collide,
  output logic            st_err,
  output logic [DLYW-1:0] st_delay
);

  localparam logic [DLYW-1:0] CNT_MAX = {DLYW{1'b1}};

  typedef enum logic [2:0] {
    S_IDLE, S_ARMED, S_PEND, S_FORCE, S_HALT, S_RWR, S_RES
  } st_t;

  st_t             st;
  logic            trg_data, tgt_reg;
  logic [AW-1:0]   trg_addr, tgt_addr;
  logic [DW-1:0]   fval;
  logic [DLYW-1:0] cnt;

  wire cpu_wr  = dbus_valid && dbus_we;
  wire hit     = trg_data ? (dbus_valid && dbus_addr == trg_addr)
                          : (fetch_valid && fetch_addr == trg_addr);
  wire idle    = (st == S_IDLE);
  wire cfg_ok  = cfg_we && idle;
  wire [DLYW-1:0] cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;

  assign ram_we     = (st == S_PEND && !cpu_wr) || st == S_FORCE;
  assign cpu_stall  = (st == S_FORCE);
  assign halt_req   = (st == S_HALT);
  assign reg_we     = (st == S_RWR);
  assign resume_req = (st == S_RES);
  assign ram_addr   = tgt_addr;
  assign ram_wdata  = fval;
  assign reg_addr   = tgt_addr;
  assign reg_wdata  = fval;
  assign st_armed   = (st == S_ARMED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      trg_data   <= 1'b0;
      tgt_reg    <= 1'b0;
      trg_addr   <= '0;
      tgt_addr   <= '0;
      fval       <= '0;
      cnt        <= '0;
      st_done    <= 1'b0;
      st_collide <= 1'b0;
      st_err     <= 1'b0;
      st_delay   <= '0;
    end else begin
      if (cfg_we && !idle) st_err <= 1'b1;
      if (cfg_ok) begin
        case (cfg_sel)
          2'd0: begin
            trg_data <= cfg_wdata[1];
            tgt_reg  <= cfg_wdata[2];
            if (cfg_wdata[0]) begin
              st         <= S_ARMED;
              st_done    <= 1'b0;
              st_collide <= 1'b0;
              st_err     <= 1'b0;
              st_delay   <= '0;
            end
          end
          2'd1: trg_addr <= cfg_wdata;
          2'd2: tgt_addr <= cfg_wdata;
          default: fval <= cfg_wdata[DW-1:0];
        endcase
      end
      case (st)
        S_ARMED: if (hit) begin
          cnt <= {{(DLYW-1){1'b0}}, 1'b1};
          st  <= tgt_reg ? S_HALT : S_PEND;
        end
        S_PEND: if (!cpu_wr) begin
          st       <= S_IDLE;
          st_done  <= 1'b1;
          st_delay <= cnt;
        end else begin
          st  <= S_FORCE;
          cnt <= cnt_inc;
          if (dbus_addr == tgt_addr) st_collide <= 1'b1;
        end
        S_FORCE: begin
          st       <= S_IDLE;
          st_done  <= 1'b1;
          st_delay <= cnt;
        end
        S_HALT: begin
          cnt <= cnt_inc;
          if (halt_ack) st <= S_RWR;
        end
        S_RWR: begin
          st_delay <= cnt;
          st       <= S_RES;
        end
        S_RES: begin
          st      <= S_IDLE;
          st_done <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R6
  commit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || resume_req) |=> (st_done && !st_armed));

  // R4
  mem_nohalt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !halt_req);

  // R5
  stall_after_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> $past(dbus_valid && dbus_we));

  // R9
  reg_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(halt_req && halt_ack));

  // R9
  resume_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (resume_req && !halt_req));

  // R9
  port_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we, reg_we, resume_req, halt_req}));

  // R10
  lock_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && st_armed) |=> st_err);

  // R7
  delay_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> (st_delay != '0 && st_delay <= 2));

endmodule

// File: tb/test_flip_inject_unit.sv
module test_flip_inject_unit;
  localparam int CLK_P = 10;
  localparam int AW = 16, DW = 8, DLYW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [AW-1:0] cfg_wdata = 0;
  logic fetch_valid = 0; logic [AW-1:0] fetch_addr = 0;
  logic dbus_valid = 0, dbus_we = 0; logic [AW-1:0] dbus_addr = 0;
  logic halt_ack = 0;
  logic ram_we, cpu_stall, halt_req, reg_we, resume_req;
  logic [AW-1:0] ram_addr, reg_addr;
  logic [DW-1:0] ram_wdata, reg_wdata;
  logic st_armed, st_done, st_collide, st_err;
  logic [DLYW-1:0] st_delay;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  flip_inject_unit #(.AW(AW), .DW(DW), .DLYW(DLYW)) i_flip_inject_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .dbus_valid(dbus_valid), .dbus_we(dbus_we), .dbus_addr(dbus_addr),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .cpu_stall(cpu_stall),
    .halt_req(halt_req), .halt_ack(halt_ack), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .resume_req(resume_req), .st_armed(st_armed), .st_done(st_done),
    .st_collide(st_collide), .st_err(st_err), .st_delay(st_delay));

  // kind: 0 fetch trigger, 1 data trigger; conf: 0 none, 1 CPU writes other address, 2 CPU writes target
  localparam int NV = 6;
  localparam int V_KIND[NV] = '{0, 1, 0, 1, 0, 1};
  localparam int V_TRG [NV] = '{16'h0040, 16'h2000, 16'h0104, 16'h2010, 16'h0ffe, 16'h2222};
  localparam int V_TGT [NV] = '{16'h3000, 16'h3001, 16'h3080, 16'h30ff, 16'h3abc, 16'h3002};
  localparam int V_VAL [NV] = '{8'h01, 8'h80, 8'h5a, 8'hfe, 8'h10, 8'h7f};
  localparam int V_CONF[NV] = '{0, 0, 1, 2, 2, 1};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int sel, input int data);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel[1:0]; cfg_wdata = data[AW-1:0];
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic arm(input int kind, input int trg, input int tgt, input int val, input int regt);
    cfg_write(1, trg); cfg_write(2, tgt); cfg_write(3, val);
    cfg_write(0, 1 | (kind << 1) | (regt << 2));
  endtask

  task automatic drive_trig(input int kind, input int a);
    if (kind == 0) begin fetch_valid = 1; fetch_addr = a[AW-1:0]; end
    else begin dbus_valid = 1; dbus_we = 0; dbus_addr = a[AW-1:0]; end
  endtask

  task automatic idle_bus();
    fetch_valid = 0; dbus_valid = 0; dbus_we = 0;
  endtask

  initial begin
    #(CLK_P*100000);
    n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ram_we", ram_we, 0); chk("R1 halt_req", halt_req, 0);
    chk("R1 armed", st_armed, 0); chk("R1 done", st_done, 0);
    chk("R1 err", st_err, 0); chk("R1 delay", st_delay, 0);

    for (int v = 0; v < NV; v++) begin
      arm(V_KIND[v], V_TRG[v], V_TGT[v], V_VAL[v], 0);
      chk("R2 armed", st_armed, 1); chk("R2 done cleared", st_done, 0);
      drive_trig(V_KIND[v], V_TRG[v]);
      #1 chk("R4 no write in match cycle", ram_we, 0);
      @(negedge clk);
      idle_bus();
      if (V_CONF[v] != 0) begin
        dbus_valid = 1; dbus_we = 1;
        dbus_addr = (V_CONF[v] == 2) ? V_TGT[v][AW-1:0] : V_TGT[v][AW-1:0] ^ 16'h0001;
      end
      #1;
      chk("R3 R4 write after match", ram_we, V_CONF[v] == 0);
      chk("R4 no halt", halt_req, 0);
      if (V_CONF[v] != 0) begin
        @(negedge clk);
        idle_bus();
        #1;
        chk("R5 forced write", ram_we, 1);
        chk("R5 stall", cpu_stall, 1);
      end
      chk("R4 addr", ram_addr, V_TGT[v]);
      chk("R4 data", ram_wdata, V_VAL[v]);
      @(negedge clk);
      chk("R6 done", st_done, 1); chk("R6 disarmed", st_armed, 0);
      chk("R7 delay", st_delay, (V_CONF[v] != 0) ? 2 : 1);
      chk("R8 collision", st_collide, V_CONF[v] == 2);
      chk("R6 no second write", ram_we, 0);
    end

    // R6 one-shot: repeat trigger of last vector
    drive_trig(V_KIND[NV-1], V_TRG[NV-1]);
    @(negedge clk); idle_bus(); #1;
    chk("R6 retrigger no write", ram_we, 0);

    // R3 and R10: non-matching accesses, refused config write
    arm(0, 16'h0100, 16'h3100, 8'h04, 0);
    fetch_valid = 1; fetch_addr = 16'h0101;
    dbus_valid = 1; dbus_we = 0; dbus_addr = 16'h0100;
    @(negedge clk); #1;
    chk("R3 other source ignored", ram_we, 0);
    chk("R3 still armed", st_armed, 1);
    idle_bus();
    cfg_write(3, 8'hee);
    chk("R10 err set", st_err, 1);
    cfg_write(2, 16'h3555);
    drive_trig(0, 16'h0100);
    @(negedge clk); idle_bus(); #1;
    chk("R10 old target kept", ram_addr, 16'h3100);
    chk("R10 old value kept", ram_wdata, 8'h04);
    chk("R10 write happens", ram_we, 1);

    // R9 register target with delayed ack
    arm(1, 16'h2400, 16'h0007, 8'h20, 1);
    chk("R2 err cleared by arm", st_err, 0);
    drive_trig(1, 16'h2400);
    @(negedge clk); idle_bus(); #1;
    chk("R9 halt requested", halt_req, 1);
    chk("R9 no ram write", ram_we, 0);
    @(negedge clk); #1;
    chk("R9 halt held", halt_req, 1); chk("R9 no reg write before ack", reg_we, 0);
    @(negedge clk); halt_ack = 1;
    @(negedge clk); halt_ack = 0; #1;
    chk("R9 reg write", reg_we, 1); chk("R9 halt dropped", halt_req, 0);
    chk("R9 reg addr", reg_addr, 16'h0007); chk("R9 reg data", reg_wdata, 8'h20);
    @(negedge clk); #1;
    chk("R9 resume", resume_req, 1); chk("R9 done not yet", st_done, 0);
    @(negedge clk); #1;
    chk("R9 done", st_done, 1); chk("R9 resume one cycle", resume_req, 0);
    chk("R7 reg delay", st_delay, 4);

    // R7 saturation
    arm(0, 16'h0500, 16'h0003, 8'h02, 1);
    drive_trig(0, 16'h0500);
    @(negedge clk); idle_bus();
    repeat (20) @(negedge clk);
    halt_ack = 1;
    @(negedge clk); halt_ack = 0;
    @(negedge clk); @(negedge clk); #1;
    chk("R7 saturated delay", st_delay, 15);
    chk("R9 done after long halt", st_done, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule